// File: doc/BRIEF.md
# Instruction Reuse Buffer

This block remembers the results of recently executed instructions so that a later instance of the same instruction can skip execution. Storage is 4-way set-associative and indexed by the instruction address (a word address). Each entry holds a tag, the result, the two source register names, an optional link to the entry that produced its input, a valid bit and a reused-recently bit. Reusability is proved by validity and by the producer chain, never by comparing operand values.

Three ports drive it. The lookup port presents an instruction address, two source register names and an inputs-ready flag, and one cycle later returns a response with a reuse-hit flag, the saved result and the slot that hit. The insert port records a finished instruction: its address, sources, result and, when its input came from a buffered instruction, that producer's slot. The slot the insert will write is reported on `ins_slot` in the same cycle, so the caller can use it as a link later. The register-write port names an architectural register being overwritten, and every entry that reads that register loses its validity.

Lookup and insert use valid/ready handshakes. The buffer never applies back-pressure: `lk_ready` and `ins_ready` stay high, so every cycle with a valid is accepted. The lookup response is a single-cycle pulse with no ready, and the caller must take it when `rsp_valid` is high. The register-write port is a plain strobe.

Top module: `reuse_buffer`

## Requirements
- R1: After reset no entry is valid: `rsp_valid` is low and a lookup of any address returns `rsp_hit`=0.
- R2: A lookup accepted at edge k gives `rsp_valid`=1 in the following cycle. `rsp_hit`=1, with `rsp_result` equal to the stored result and `rsp_slot` equal to {set,way}, when a valid way has a matching tag, both source names match, inputs-ready is high, and the entry either has no link or its producer's reused bit is set. On a miss, `rsp_result` and `rsp_slot` are zero.
- R3: A lookup with `lk_inputs_rdy` low never hits.
- R4: A lookup whose source names differ from those of the matching entry never hits.
- R5: A register write clears the valid and reused bits of every entry whose first or second source equals the written name. A lookup presented in the same cycle as a write to one of its sources does not hit.
- R6: The reused bit of an entry is set when it hits. It is cleared by a lookup that matches its tag but does not hit, by insertion into its slot and by invalidation. A linked entry hits only while its producer's reused bit is set.
- R7: The set index is address bits [log2(SETS)-1:0] and the tag is the bits above them. Four instructions with the same index coexist.
- R8: An insert writes the way of its set whose valid tag matches, else the lowest invalid way, else the pseudo-LRU victim. `ins_slot` = set*4+way is valid combinationally in the same cycle. Tree state per set is 3 bits t, reset to 0. The victim is way t[1] when t[0]=0, and way 2+t[2] when t[0]=1. A hit or insert on way w sets t[0]=1 and t[1]=(w==0) for w<2, and sets t[0]=0 and t[2]=(w==2) otherwise. When an insert and a hit touch the same set in one cycle, the insert is applied after the hit.
- R9: An insert clears the valid and reused bits of every other entry whose link points at the written slot.
- R10: `lk_ready` and `ins_ready` are always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup accepted (always 1) |
| lk_pc | input | PC_W | Instruction word address of lookup |
| lk_src1 | input | REG_W | First source register name |
| lk_src2 | input | REG_W | Second source register name |
| lk_inputs_rdy | input | 1 | Operands ready for the reuse test |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Instruction may be reused |
| rsp_result | output | DATA_W | Saved result on hit |
| rsp_slot | output | SLOT_W | Slot that hit |
| ins_valid | input | 1 | Insert request valid |
| ins_ready | output | 1 | Insert accepted (always 1) |
| ins_pc | input | PC_W | Address of finished instruction |
| ins_src1 | input | REG_W | Its first source name |
| ins_src2 | input | REG_W | Its second source name |
| ins_result | input | DATA_W | Its result |
| ins_link_valid | input | 1 | Input came from a buffered producer |
| ins_link | input | SLOT_W | Producer slot |
| ins_slot | output | SLOT_W | Slot this insert writes |
| wr_valid | input | 1 | Register overwrite strobe |
| wr_reg | input | REG_W | Overwritten register name |

## Verification
A stale valid or reused bit shows up as a hit that should be a miss (or the reverse) on the first lookup of the affected entry, or of any entry linked to it, one cycle after that lookup is presented. A wrong pseudo-LRU state or a wrong slot choice appears at once on `ins_slot` when an insert reaches a full set. A missed eviction of a dependent shows at the next lookup of that dependent. The reference model follows the requirements cycle by cycle. It compares every response and every insert slot, so any divergence is reported in the cycle it first reaches a port.

// File: rtl/irb_pkg.sv
package irb_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef logic [2:0] plru_t;

  function automatic plru_t plru_touch(plru_t t, logic [WAY_W-1:0] w);
    plru_t r;
    r = t;
    if (!w[1]) begin
      r[0] = 1'b1;
      r[1] = ~w[0];
    end else begin
      r[0] = 1'b0;
      r[2] = ~w[0];
    end
    return r;
  endfunction

  function automatic logic [WAY_W-1:0] plru_victim(plru_t t);
    return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
  endfunction
endpackage

// File: rtl/irb_way_cmp.sv
module irb_way_cmp #(
  parameter int TAG_W = 26,
  parameter int REG_W = 5
) (
  input  logic             e_valid,
  input  logic [TAG_W-1:0] e_tag,
  input  logic [REG_W-1:0] e_src1,
  input  logic [REG_W-1:0] e_src2,
  input  logic             e_linked,
  input  logic             prod_reused,
  input  logic [TAG_W-1:0] q_tag,
  input  logic [REG_W-1:0] q_src1,
  input  logic [REG_W-1:0] q_src2,
  input  logic             q_inputs_rdy,
  input  logic             wr_valid,
  input  logic [REG_W-1:0] wr_reg,
  output logic             tag_hit,
  output logic             reuse_ok
);
  logic names_eq, chain_ok, clobbered;

  assign tag_hit   = e_valid && (e_tag == q_tag);
  assign names_eq  = (e_src1 == q_src1) && (e_src2 == q_src2);
  assign chain_ok  = !e_linked || prod_reused;
  assign clobbered = wr_valid && ((wr_reg == q_src1) || (wr_reg == q_src2));
  assign reuse_ok  = tag_hit && names_eq && chain_ok && q_inputs_rdy && !clobbered;
endmodule

// File: rtl/irb_plru_bank.sv
module irb_plru_bank
  import irb_pkg::*;
#(
  parameter int SETS  = 64,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_valid,
  input  logic [IDX_W-1:0] a_set,
  input  logic [WAY_W-1:0] a_way,
  input  logic             b_valid,
  input  logic [IDX_W-1:0] b_set,
  input  logic [WAY_W-1:0] b_way,
  input  logic [IDX_W-1:0] q_set,
  output logic [WAY_W-1:0] q_victim
);
  plru_t st  [SETS];
  plru_t nxt [SETS];

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      nxt[s] = st[s];
      if (a_valid && (a_set == IDX_W'(s))) nxt[s] = plru_touch(nxt[s], a_way);
      if (b_valid && (b_set == IDX_W'(s))) nxt[s] = plru_touch(nxt[s], b_way);
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < SETS; s++) begin
      if (!rst_n) st[s] <= '0;
      else        st[s] <= nxt[s];
    end
  end

  assign q_victim = plru_victim(st[q_set]);

  a_r8_touch_moves_away: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !(a_valid && a_set == b_set)) |=> (plru_victim(st[$past(b_set)]) != $past(b_way)));
endmodule

// File: rtl/reuse_buffer.sv
module reuse_buffer
  import irb_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int REG_W  = 5,
  parameter int DATA_W = 64,
  parameter int SETS   = 64,
  localparam int IDX_W  = $clog2(SETS),
  localparam int SLOT_W = IDX_W + WAY_W,
  localparam int TAG_W  = PC_W - IDX_W,
  localparam int N      = SETS * WAYS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [REG_W-1:0]  lk_src1,
  input  logic [REG_W-1:0]  lk_src2,
  input  logic              lk_inputs_rdy,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_result,
  output logic [SLOT_W-1:0] rsp_slot,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [PC_W-1:0]   ins_pc,
  input  logic [REG_W-1:0]  ins_src1,
  input  logic [REG_W-1:0]  ins_src2,
  input  logic [DATA_W-1:0] ins_result,
  input  logic              ins_link_valid,
  input  logic [SLOT_W-1:0] ins_link,
  output logic [SLOT_W-1:0] ins_slot,
  input  logic              wr_valid,
  input  logic [REG_W-1:0]  wr_reg
);
  logic              ent_v   [N];
  logic [TAG_W-1:0]  ent_tag [N];
  logic [REG_W-1:0]  ent_s1  [N];
  logic [REG_W-1:0]  ent_s2  [N];
  logic [DATA_W-1:0] ent_res [N];
  logic              ent_lkv [N];
  logic [SLOT_W-1:0] ent_lk  [N];
  logic              ent_ru  [N];

  assign lk_ready  = 1'b1;
  assign ins_ready = 1'b1;

  // Lookup side
  logic [IDX_W-1:0] l_set;
  logic [TAG_W-1:0] l_tag;
  logic [WAYS-1:0]  l_tag_vec, l_ok_vec;
  logic             l_any, l_ok;
  logic [WAY_W-1:0] l_way;
  logic [SLOT_W-1:0] l_slot;

  assign l_set = lk_pc[IDX_W-1:0];
  assign l_tag = lk_pc[PC_W-1:IDX_W];

  // Insert side
  logic [IDX_W-1:0] i_set;
  logic [TAG_W-1:0] i_tag;
  logic [WAYS-1:0]  i_teq, i_free;
  logic [WAY_W-1:0] i_victim, i_way;

  assign i_set = ins_pc[IDX_W-1:0];
  assign i_tag = ins_pc[PC_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    localparam logic [WAY_W-1:0] WI = WAY_W'(w);
    logic [SLOT_W-1:0] ls, is;
    assign ls = {l_set, WI};
    assign is = {i_set, WI};

    irb_way_cmp #(.TAG_W(TAG_W), .REG_W(REG_W)) u_cmp (
      .e_valid     (ent_v[ls]),
      .e_tag       (ent_tag[ls]),
      .e_src1      (ent_s1[ls]),
      .e_src2      (ent_s2[ls]),
      .e_linked    (ent_lkv[ls]),
      .prod_reused (ent_ru[ent_lk[ls]]),
      .q_tag       (l_tag),
      .q_src1      (lk_src1),
      .q_src2      (lk_src2),
      .q_inputs_rdy(lk_inputs_rdy),
      .wr_valid    (wr_valid),
      .wr_reg      (wr_reg),
      .tag_hit     (l_tag_vec[w]),
      .reuse_ok    (l_ok_vec[w])
    );

    assign i_teq[w]  = ent_v[is] && (ent_tag[is] == i_tag);
    assign i_free[w] = !ent_v[is];
  end

  always_comb begin
    l_any = 1'b0;
    l_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (l_tag_vec[w]) begin
        l_any = 1'b1;
        l_way = WAY_W'(w);
      end
    end
  end
  assign l_ok   = lk_valid && l_any && l_ok_vec[l_way];
  assign l_slot = {l_set, l_way};

  always_comb begin
    i_way = i_victim;
    for (int w = WAYS - 1; w >= 0; w--) if (i_free[w]) i_way = WAY_W'(w);
    for (int w = WAYS - 1; w >= 0; w--) if (i_teq[w])  i_way = WAY_W'(w);
  end
  assign ins_slot = {i_set, i_way};

  irb_plru_bank #(.SETS(SETS)) u_plru (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_valid (l_ok),
    .a_set   (l_set),
    .a_way   (l_way),
    .b_valid (ins_valid),
    .b_set   (i_set),
    .b_way   (i_way),
    .q_set   (i_set),
    .q_victim(i_victim)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_result <= '0;
      rsp_slot   <= '0;
      for (int i = 0; i < N; i++) begin
        ent_v[i]   <= 1'b0;
        ent_ru[i]  <= 1'b0;
        ent_lkv[i] <= 1'b0;
        ent_lk[i]  <= '0;
        ent_tag[i] <= '0;
        ent_s1[i]  <= '0;
        ent_s2[i]  <= '0;
        ent_res[i] <= '0;
      end
    end else begin
      rsp_valid  <= lk_valid;
      rsp_hit    <= l_ok;
      rsp_result <= l_ok ? ent_res[l_slot] : '0;
      rsp_slot   <= l_ok ? l_slot : '0;

      if (lk_valid && l_any) ent_ru[l_slot] <= l_ok;

      if (ins_valid) begin
        ent_v[ins_slot]   <= 1'b1;
        ent_ru[ins_slot]  <= 1'b0;
        ent_tag[ins_slot] <= i_tag;
        ent_s1[ins_slot]  <= ins_src1;
        ent_s2[ins_slot]  <= ins_src2;
        ent_res[ins_slot] <= ins_result;
        ent_lkv[ins_slot] <= ins_link_valid;
        ent_lk[ins_slot]  <= ins_link;
      end

      for (int i = 0; i < N; i++) begin
        if ((ins_valid && ent_lkv[i] && (ent_lk[i] == ins_slot) && (SLOT_W'(i) != ins_slot)) ||
            (wr_valid && ((((ins_valid && SLOT_W'(i) == ins_slot) ? ins_src1 : ent_s1[i]) == wr_reg) ||
                          (((ins_valid && SLOT_W'(i) == ins_slot) ? ins_src2 : ent_s2[i]) == wr_reg)))) begin
          ent_v[i]  <= 1'b0;
          ent_ru[i] <= 1'b0;
        end
      end
    end
  end

  a_r3_not_ready_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_inputs_rdy) |=> !rsp_hit);
  a_r2_hit_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
  a_r5_same_cycle_clobber: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && wr_valid && ((wr_reg == lk_src1) || (wr_reg == lk_src2))) |=> !rsp_hit);
  a_r7_single_tag_way: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(l_tag_vec));
  a_r1_idle_no_response: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
endmodule

// File: tb/sim_reuse_buffer.sv
module sim_reuse_buffer;
  localparam int PC_W = 32, REG_W = 5, DATA_W = 64, SETS = 64, N = 256, SLOT_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, lk_inputs_rdy = 0, ins_valid = 0, ins_link_valid = 0, wr_valid = 0;
  logic [PC_W-1:0] lk_pc = '0, ins_pc = '0;
  logic [REG_W-1:0] lk_src1 = '0, lk_src2 = '0, ins_src1 = '0, ins_src2 = '0, wr_reg = '0;
  logic [DATA_W-1:0] ins_result = '0;
  logic [SLOT_W-1:0] ins_link = '0;
  logic lk_ready, ins_ready, rsp_valid, rsp_hit;
  logic [DATA_W-1:0] rsp_result;
  logic [SLOT_W-1:0] rsp_slot, ins_slot;

  always #10 clk = ~clk;

  reuse_buffer #(.PC_W(PC_W), .REG_W(REG_W), .DATA_W(DATA_W), .SETS(SETS)) u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc), .lk_src1(lk_src1),
    .lk_src2(lk_src2), .lk_inputs_rdy(lk_inputs_rdy),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_result(rsp_result), .rsp_slot(rsp_slot),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_pc(ins_pc), .ins_src1(ins_src1),
    .ins_src2(ins_src2), .ins_result(ins_result), .ins_link_valid(ins_link_valid),
    .ins_link(ins_link), .ins_slot(ins_slot), .wr_valid(wr_valid), .wr_reg(wr_reg)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // behavioural model state
  bit m_v [N]; int m_tag [N]; int m_s1 [N]; int m_s2 [N];
  logic [DATA_W-1:0] m_res [N];
  bit m_lkv [N]; int m_lk [N]; bit m_ru [N];
  bit [2:0] m_pl [SETS];
  int last_slot;

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_victim(int s);
    if (m_pl[s][0] == 1'b0) return m_pl[s][1] ? 1 : 0;
    return m_pl[s][2] ? 3 : 2;
  endfunction

  function automatic void m_touch(int s, int w);
    if (w < 2) begin m_pl[s][0] = 1'b1; m_pl[s][1] = (w == 0); end
    else       begin m_pl[s][0] = 1'b0; m_pl[s][2] = (w == 2); end
  endfunction

  function automatic int m_pick(int pc);
    int s = pc % SETS, t = pc / SETS;
    for (int w = 0; w < 4; w++) if (m_v[s*4+w] && m_tag[s*4+w] == t) return s*4+w;
    for (int w = 0; w < 4; w++) if (!m_v[s*4+w]) return s*4+w;
    return s*4 + m_victim(s);
  endfunction

  task automatic tick(input string req);
    int pick, hw, ls, lt;
    bit ok, e_v, e_hit;
    logic [DATA_W-1:0] e_res;
    int e_slot;
    #1;
    pick = m_pick(int'(ins_pc));
    last_slot = pick;
    if (ins_valid) chk("R8 insert slot", ins_slot, pick);
    chk("R10 ready", {lk_ready, ins_ready}, 2'b11);
    ls = int'(lk_pc) % SETS; lt = int'(lk_pc) / SETS; hw = -1;
    for (int w = 3; w >= 0; w--) if (m_v[ls*4+w] && m_tag[ls*4+w] == lt) hw = ls*4+w;
    ok = lk_valid && lk_inputs_rdy && hw >= 0;
    if (ok) ok = m_s1[hw] == int'(lk_src1) && m_s2[hw] == int'(lk_src2) &&
                 (!m_lkv[hw] || m_ru[m_lk[hw]]) &&
                 !(wr_valid && (wr_reg == lk_src1 || wr_reg == lk_src2));
    e_v = lk_valid; e_hit = ok; e_res = ok ? m_res[hw] : '0; e_slot = ok ? hw : 0;
    if (lk_valid && hw >= 0) begin m_ru[hw] = ok; if (ok) m_touch(ls, hw % 4); end
    if (ins_valid) begin
      m_v[pick] = 1; m_ru[pick] = 0; m_tag[pick] = int'(ins_pc) / SETS;
      m_s1[pick] = int'(ins_src1); m_s2[pick] = int'(ins_src2); m_res[pick] = ins_result;
      m_lkv[pick] = ins_link_valid; m_lk[pick] = int'(ins_link);
      m_touch(pick / 4, pick % 4);
      for (int i = 0; i < N; i++)
        if (i != pick && m_lkv[i] && m_lk[i] == pick) begin m_v[i] = 0; m_ru[i] = 0; end
    end
    if (wr_valid)
      for (int i = 0; i < N; i++)
        if (m_s1[i] == int'(wr_reg) || m_s2[i] == int'(wr_reg)) begin m_v[i] = 0; m_ru[i] = 0; end
    @(negedge clk);
    chk({req, " rsp_valid"}, rsp_valid, e_v);
    chk({req, " rsp_hit"}, rsp_hit, e_hit);
    chk({req, " rsp_result"}, rsp_result, e_res);
    chk({req, " rsp_slot"}, rsp_slot, e_slot);
  endtask

  task automatic idle();
    lk_valid = 0; ins_valid = 0; wr_valid = 0; ins_link_valid = 0;
  endtask

  task automatic look(input int pc, input int a, input int b, input bit rdy, input string req);
    idle(); lk_valid = 1; lk_pc = pc; lk_src1 = a; lk_src2 = b; lk_inputs_rdy = rdy;
    tick(req);
  endtask

  task automatic put(input int pc, input int a, input int b, input logic [63:0] r,
                     input bit lv, input int lk, input string req);
    idle(); ins_valid = 1; ins_pc = pc; ins_src1 = a; ins_src2 = b; ins_result = r;
    ins_link_valid = lv; ins_link = lk;
    tick(req);
  endtask

  initial begin
    int sa, sp, sb;
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_ru[i] = 0; m_lkv[i] = 0; m_lk[i] = 0; m_tag[i] = 0;
      m_s1[i] = 0; m_s2[i] = 0; m_res[i] = '0;
    end
    for (int s = 0; s < SETS; s++) m_pl[s] = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 reset rsp_valid", rsp_valid, 0);
    look('h40, 1, 2, 1, "R1 empty lookup");
    chk("R1 empty no hit", rsp_hit, 0);

    put('h40, 1, 2, 64'hAAAA_0001, 0, 0, "R8 first insert"); sa = last_slot;
    chk("R8 first slot", sa, 0);
    look('h40, 1, 2, 1, "R2 head hit");
    chk("R2 literal hit", rsp_hit, 1);
    chk("R2 literal result", rsp_result, 64'hAAAA_0001);
    look('h40, 1, 2, 0, "R3 not ready");
    chk("R3 literal miss", rsp_hit, 0);
    look('h40, 3, 2, 1, "R4 name differs");
    chk("R4 literal miss", rsp_hit, 0);

    put('h81, 5, 6, 64'hBBBB, 1, sa, "R6 chained insert"); sb = last_slot;
    look('h81, 5, 6, 1, "R6 producer not reused");
    chk("R6 literal miss", rsp_hit, 0);
    look('h40, 1, 2, 1, "R6 producer hit");
    look('h81, 5, 6, 1, "R6 chained hit");
    chk("R6 literal chained hit", rsp_hit, 1);
    chk("R6 literal slot", rsp_slot, sb);

    idle(); wr_valid = 1; wr_reg = 2; tick("R5 write");
    look('h40, 1, 2, 1, "R5 after overwrite");
    chk("R5 literal miss", rsp_hit, 0);
    look('h81, 5, 6, 1, "R6 producer invalid");

    put('hC0, 7, 8, 64'hCCCC, 0, 0, "R7 second tag set 0");
    idle(); lk_valid = 1; lk_pc = 'hC0; lk_src1 = 7; lk_src2 = 8; lk_inputs_rdy = 1;
    wr_valid = 1; wr_reg = 8; tick("R5 same cycle write");
    chk("R5 literal same cycle", rsp_hit, 0);
    look('hC0, 7, 8, 1, "R5 entry gone");

    put('h42, 1, 1, 64'h1, 0, 0, "R7 fill");
    put('h82, 1, 1, 64'h2, 0, 0, "R7 fill");
    put('hC2, 1, 1, 64'h3, 0, 0, "R7 fill");
    put('h102, 1, 1, 64'h4, 0, 0, "R7 fill");
    look('h82, 1, 1, 1, "R7 coexist");
    chk("R7 literal hit", rsp_hit, 1);
    look('h102, 1, 1, 1, "R7 coexist");
    put('h142, 1, 1, 64'h5, 0, 0, "R8 eviction");
    chk("R8 literal victim slot", last_slot, 8);
    look('h42, 1, 1, 1, "R8 evicted");
    chk("R8 literal evicted miss", rsp_hit, 0);

    put('h04, 9, 10, 64'h77, 0, 0, "R9 producer"); sp = last_slot;
    put('h05, 11, 12, 64'h88, 1, sp, "R9 dependent");
    look('h04, 9, 10, 1, "R9 producer hit");
    look('h05, 11, 12, 1, "R9 dependent hit");
    chk("R9 literal dep hit", rsp_hit, 1);
    put('h04, 9, 10, 64'h99, 0, 0, "R9 rewrite producer");
    look('h04, 9, 10, 1, "R9 producer hit again");
    look('h05, 11, 12, 1, "R9 dependent dropped");
    chk("R9 literal dep miss", rsp_hit, 0);

    for (int c = 0; c < 4000; c++) begin
      idle();
      lk_valid = ($urandom % 10) < 6;
      lk_pc = (1 + $urandom % 3) * SETS + $urandom % 4;
      lk_src1 = 1 + $urandom % 4; lk_src2 = 1 + $urandom % 4;
      lk_inputs_rdy = ($urandom % 8) != 0;
      ins_valid = ($urandom % 10) < 3;
      ins_pc = (1 + $urandom % 3) * SETS + $urandom % 4;
      ins_src1 = 1 + $urandom % 4; ins_src2 = 1 + $urandom % 4;
      ins_result = {$urandom, $urandom};
      ins_link_valid = $urandom % 2; ins_link = $urandom % 16;
      wr_valid = ($urandom % 20) < 3; wr_reg = 1 + $urandom % 4;
      tick("R2 R6 random");
    end
    idle(); tick("R1 idle");

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule